// File: doc/BRIEF.md
# CAN Error State Tracker

This block keeps the two fault-confinement counters of a CAN node, one for reception and one for transmission, and turns their values into status flags. Upstream logic reports each bus error or successful frame as an increment strobe with a step size, or as a decrement strobe. The block adds or subtracts, saturates, and compares each counter against its own thresholds. From those comparisons it derives a warning flag and an error-passive flag for each direction, plus a bus-off flag driven by the transmit counter.

The buffer manager reports receive overflows, one bit per receive buffer. Each report sets a sticky flag that only software clears. A single error-interrupt strobe tells the host that something changed: any status flag rising or falling, or any overflow report.

Once the node is bus-off, the counters are frozen. The only way out is an explicit recovery request, which returns the counters and every flag to zero.

Top module: `can_err_tracker`

## Requirements
- R1: `rx_inc` adds `rx_step` to the receive counter and `rx_dec` subtracts one; the transmit counter behaves the same with `tx_inc`, `tx_step` and `tx_dec`; when increment and decrement arrive in the same cycle only the increment is applied. Counters update at the clock edge that samples the strobe.
- R2: The 8-bit receive counter saturates at 255 instead of wrapping, and a decrement of either counter at zero leaves it at zero.
- R3: `rx_warn` / `tx_warn` is 1 while the matching counter is at least 96, and returns to 0 when the counter falls below 96.
- R4: `rx_passive` / `tx_passive` is 1 while the matching counter is above 127, and returns to 0 when the counter is back to 127 or less.
- R5: `bus_off` is 1 once the 9-bit transmit counter exceeds 255. While it is 1, all increment and decrement strobes are ignored and both counters hold.
- R6: `recover` clears both counters, all status flags and all overflow flags at the next edge. It takes priority over every other input in the same cycle.
- R7: `ovf_event[i]` sets `ovf_flag[i]`, which stays 1 until `ovf_clr[i]`. A set and a clear of the same bit in one cycle leave the bit at 1.
- R8: `err_irq` is 1 for exactly the cycle after any edge at which one of the five status flags changed value, or at which an overflow event was taken (not under `recover`). Otherwise it is 0.
- R9: After synchronous reset the counters, all flags and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_inc | input | 1 | Add `rx_step` to the receive counter |
| rx_step | input | 4 | Receive increment amount |
| rx_dec | input | 1 | Subtract one from the receive counter |
| tx_inc | input | 1 | Add `tx_step` to the transmit counter |
| tx_step | input | 4 | Transmit increment amount |
| tx_dec | input | 1 | Subtract one from the transmit counter |
| ovf_event | input | 2 | Per-buffer receive overflow report |
| ovf_clr | input | 2 | Per-buffer software clear of the overflow flag |
| recover | input | 1 | Clear counters and flags, leave bus-off |
| rx_cnt | output | 8 | Receive error counter |
| tx_cnt | output | 9 | Transmit error counter |
| rx_warn | output | 1 | Receive counter at or above 96 |
| tx_warn | output | 1 | Transmit counter at or above 96 |
| rx_passive | output | 1 | Receive counter above 127 |
| tx_passive | output | 1 | Transmit counter above 127 |
| bus_off | output | 1 | Transmit counter above 255 |
| ovf_flag | output | 2 | Sticky per-buffer overflow flags |
| err_irq | output | 1 | One-cycle error-interrupt strobe |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an overflow report and a counter step that crosses a threshold: the bench drives `ovf_event` in the very cycle the transmit counter moves from 120 to 128. It then expects the overflow flag, the new passive flag and a single `err_irq` pulse together, and no pulse in the following cycle. The second pair is a recovery request and other activity: `recover` is issued together with an increment and an overflow report. The bench checks that recovery wins, leaving zero counts, no overflow flag and one interrupt for the dropped status.

// File: rtl/can_err_pkg.sv
// Package: shared types and default limits for the CAN error state tracker.
// Assumes: the flag order of status_t is the order the top module reports.
package can_err_pkg;

    // Default thresholds for fault confinement
    localparam int WARN_LIMIT_DEF    = 96;
    localparam int PASSIVE_LIMIT_DEF = 127;
    localparam int BUSOFF_LIMIT_DEF  = 255;

    // Status flags of the node, compared as a whole to detect changes
    typedef struct packed {
        logic bus_off;
        logic tx_passive;
        logic rx_passive;
        logic tx_warn;
        logic rx_warn;
    } status_t;

endpackage

// File: rtl/can_sat_counter.sv
// Module: saturating up/down error counter.
// Adds a step on inc, subtracts one on dec (inc wins), saturates at all-ones,
// stops at zero. clr forces zero and beats everything; hold freezes the value.
// Assumes: STEP_W <= W.
module can_sat_counter #(
    parameter int W      = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hold,
    input  logic              inc,
    input  logic [STEP_W-1:0] step,
    input  logic              dec,
    output logic [W-1:0]      cnt
);

    localparam logic [W-1:0] MAXV = '1;
    localparam int           PADW = W + 1 - STEP_W;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic [W:0]   sum_w;

    // Next count: clear, hold, saturating add or floored subtract
    always_comb begin
        sum_w = {1'b0, cnt_q} + {{PADW{1'b0}}, step};
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (inc) begin
                cnt_d = sum_w[W] ? MAXV : sum_w[W-1:0];
            end else if (dec && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Count register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && inc && cnt_q == MAXV) |=> (cnt_q == MAXV));

    assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && !inc && dec && cnt_q == '0) |=> (cnt_q == '0));

    assert_inc_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && inc && dec && step != '0 && cnt_q != MAXV) |=> (cnt_q > $past(cnt_q)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hold) |=> $stable(cnt_q));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/can_dir_status.sv
// Module: threshold comparators for one direction's counter.
// Raises warn at or above WARN_LIM and passive strictly above PASS_LIM.
// Assumes: both limits fit in W bits and WARN_LIM < PASS_LIM.
module can_dir_status #(
    parameter int W        = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 127
) (
    input  logic [W-1:0] cnt,
    output logic         warn,
    output logic         passive
);

    localparam logic [W-1:0] WARN_V = W'(WARN_LIM);
    localparam logic [W-1:0] PASS_V = W'(PASS_LIM);

    // Compare the live count against both limits
    always_comb begin
        warn    = (cnt >= WARN_V);
        passive = (cnt >  PASS_V);
    end

endmodule

// File: rtl/can_ovf_flags.sv
// Module: sticky per-buffer receive overflow flags.
// A report sets its bit, a software clear drops it (set wins), and clr_all
// drops every bit and beats both. hit pulses the cycle after any accepted report.
module can_ovf_flags #(
    parameter int NBUF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [NBUF-1:0] evt,
    input  logic [NBUF-1:0] sw_clr,
    output logic [NBUF-1:0] flags,
    output logic            hit
);

    logic [NBUF-1:0] flag_q;
    logic            hit_q;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        // One sticky overflow bit per receive buffer
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) flag_q[i] <= 1'b0;
            else if (evt[i])       flag_q[i] <= 1'b1;
            else if (sw_clr[i])    flag_q[i] <= 1'b0;
        end

        assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !clr_all) |=> flag_q[i]);

        assert_swclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[i] && !evt[i]) |=> !flag_q[i]);
    end

    // Remember that an overflow report was taken this cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) hit_q <= 1'b0;
        else                   hit_q <= |evt;
    end

    assign flags = flag_q;
    assign hit   = hit_q;

endmodule

// File: rtl/can_err_tracker.sv
// Module: CAN error state tracker (top).
// Holds the receive and transmit error counters, derives warning, passive and
// bus-off flags, keeps per-buffer overflow flags and strobes err_irq on any
// status change or overflow report. Bus-off freezes both counters until recover.
// Assumes: step sizes are resolved upstream; TX_W is wide enough to exceed BOFF_LIM.
module can_err_tracker
    import can_err_pkg::*;
#(
    parameter int RX_W     = 8,
    parameter int TX_W     = 9,
    parameter int STEP_W   = 4,
    parameter int NBUF     = 2,
    parameter int WARN_LIM = WARN_LIMIT_DEF,
    parameter int PASS_LIM = PASSIVE_LIMIT_DEF,
    parameter int BOFF_LIM = BUSOFF_LIMIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_inc,
    input  logic [STEP_W-1:0] rx_step,
    input  logic              rx_dec,
    input  logic              tx_inc,
    input  logic [STEP_W-1:0] tx_step,
    input  logic              tx_dec,
    input  logic [NBUF-1:0]   ovf_event,
    input  logic [NBUF-1:0]   ovf_clr,
    input  logic              recover,
    output logic [RX_W-1:0]   rx_cnt,
    output logic [TX_W-1:0]   tx_cnt,
    output logic              rx_warn,
    output logic              tx_warn,
    output logic              rx_passive,
    output logic              tx_passive,
    output logic              bus_off,
    output logic [NBUF-1:0]   ovf_flag,
    output logic              err_irq
);

    localparam logic [TX_W-1:0] BOFF_V = TX_W'(BOFF_LIM);

    status_t status_now;
    status_t status_q;
    logic    ovf_hit;

    can_sat_counter #(.W(RX_W), .STEP_W(STEP_W)) u_rx_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (recover),
        .hold (bus_off),
        .inc  (rx_inc),
        .step (rx_step),
        .dec  (rx_dec),
        .cnt  (rx_cnt)
    );

    can_sat_counter #(.W(TX_W), .STEP_W(STEP_W)) u_tx_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (recover),
        .hold (bus_off),
        .inc  (tx_inc),
        .step (tx_step),
        .dec  (tx_dec),
        .cnt  (tx_cnt)
    );

    can_dir_status #(.W(RX_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_rx_stat (
        .cnt    (rx_cnt),
        .warn   (rx_warn),
        .passive(rx_passive)
    );

    can_dir_status #(.W(TX_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_tx_stat (
        .cnt    (tx_cnt),
        .warn   (tx_warn),
        .passive(tx_passive)
    );

    can_ovf_flags #(.NBUF(NBUF)) u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(recover),
        .evt    (ovf_event),
        .sw_clr (ovf_clr),
        .flags  (ovf_flag),
        .hit    (ovf_hit)
    );

    // Bus-off follows the frozen transmit count, so it stays set until recover
    always_comb begin
        bus_off               = (tx_cnt > BOFF_V);
        status_now.bus_off    = bus_off;
        status_now.tx_passive = tx_passive;
        status_now.rx_passive = rx_passive;
        status_now.tx_warn    = tx_warn;
        status_now.rx_warn    = rx_warn;
    end

    // Keep last cycle's status to spot any flag change
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_now;
    end

    // Interrupt strobe: a status edge or an accepted overflow report
    assign err_irq = (status_now != status_q) || ovf_hit;

    assert_busoff_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !recover) |=> bus_off);

    assert_ovf_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ovf_event) && !recover) |=> err_irq);

    assert_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (rx_cnt == '0 && tx_cnt == '0 && ovf_flag == '0 && !bus_off));

    assert_passive_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_passive) |-> err_irq);

endmodule

// File: tb/tb_can_err_tracker.sv
// Bench: vector table walked by one loop, then directed corner-case tests.
module tb_can_err_tracker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_inc, rx_dec, tx_inc, tx_dec, recover;
    logic [3:0] rx_step, tx_step;
    logic [1:0] ovf_event, ovf_clr;
    logic [7:0] rx_cnt;
    logic [8:0] tx_cnt;
    logic       rx_warn, tx_warn, rx_passive, tx_passive, bus_off, err_irq;
    logic [1:0] ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    can_err_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .rx_inc(rx_inc), .rx_step(rx_step), .rx_dec(rx_dec),
        .tx_inc(tx_inc), .tx_step(tx_step), .tx_dec(tx_dec),
        .ovf_event(ovf_event), .ovf_clr(ovf_clr), .recover(recover),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .rx_warn(rx_warn), .tx_warn(tx_warn),
        .rx_passive(rx_passive), .tx_passive(tx_passive),
        .bus_off(bus_off), .ovf_flag(ovf_flag), .err_irq(err_irq)
    );

    // Flag order: {bus_off, tx_passive, rx_passive, tx_warn, rx_warn}
    typedef struct packed {
        logic       rxi;
        logic [3:0] rxs;
        logic       rxd;
        logic       txi;
        logic [3:0] txs;
        logic       txd;
        logic [7:0] erx;
        logic [8:0] etx;
        logic [4:0] eflg;
        logic       eirq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd8,  1'b0, 1'b0, 4'd0,  1'b0, 8'd8,  9'd0,  5'b00000, 1'b0},
        '{1'b0, 4'd0,  1'b0, 1'b1, 4'd8,  1'b0, 8'd8,  9'd8,  5'b00000, 1'b0},
        '{1'b1, 4'd15, 1'b0, 1'b1, 4'd15, 1'b0, 8'd23, 9'd23, 5'b00000, 1'b0},
        '{1'b0, 4'd0,  1'b1, 1'b0, 4'd0,  1'b1, 8'd22, 9'd22, 5'b00000, 1'b0},
        '{1'b1, 4'd1,  1'b1, 1'b0, 4'd0,  1'b1, 8'd23, 9'd21, 5'b00000, 1'b0},
        '{1'b1, 4'd15, 1'b0, 1'b0, 4'd0,  1'b0, 8'd38, 9'd21, 5'b00000, 1'b0},
        '{1'b1, 4'd15, 1'b0, 1'b0, 4'd0,  1'b0, 8'd53, 9'd21, 5'b00000, 1'b0},
        '{1'b1, 4'd15, 1'b0, 1'b0, 4'd0,  1'b0, 8'd68, 9'd21, 5'b00000, 1'b0},
        '{1'b1, 4'd15, 1'b0, 1'b0, 4'd0,  1'b0, 8'd83, 9'd21, 5'b00000, 1'b0},
        '{1'b1, 4'd13, 1'b0, 1'b0, 4'd0,  1'b0, 8'd96, 9'd21, 5'b00001, 1'b1},
        '{1'b0, 4'd0,  1'b1, 1'b0, 4'd0,  1'b0, 8'd95, 9'd21, 5'b00000, 1'b1},
        '{1'b1, 4'd1,  1'b0, 1'b0, 4'd0,  1'b0, 8'd96, 9'd21, 5'b00001, 1'b1},
        '{1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 8'd96, 9'd21, 5'b00001, 1'b0}
    };

    // Drive one cycle of inputs at the falling edge, return at the next falling edge
    task automatic cyc(input logic ri, input logic [3:0] rs, input logic rd,
                       input logic ti, input logic [3:0] ts, input logic td,
                       input logic [1:0] oe, input logic [1:0] oc, input logic rec);
        rx_inc = ri; rx_step = rs; rx_dec = rd;
        tx_inc = ti; tx_step = ts; tx_dec = td;
        ovf_event = oe; ovf_clr = oc; recover = rec;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
    endtask

    // Compare every output against the expected values
    task automatic chk(input string tag, input logic [7:0] erx, input logic [8:0] etx,
                       input logic [4:0] eflg, input logic [1:0] eovf, input logic eirq);
        logic [4:0] flg;
        flg = {bus_off, tx_passive, rx_passive, tx_warn, rx_warn};
        checks++;
        if (rx_cnt !== erx || tx_cnt !== etx || flg !== eflg ||
            ovf_flag !== eovf || err_irq !== eirq) begin
            fails++;
            $display("FAIL %s: rx=%0d tx=%0d flags=%b ovf=%b irq=%b, expected rx=%0d tx=%0d flags=%b ovf=%b irq=%b",
                     tag, rx_cnt, tx_cnt, flg, ovf_flag, err_irq, erx, etx, eflg, eovf, eirq);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rx_inc = 0; rx_step = 0; rx_dec = 0; tx_inc = 0; tx_step = 0; tx_dec = 0;
        ovf_event = 0; ovf_clr = 0; recover = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R9 reset state", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b0);

        // Table walk: R1 steps and inc priority, R3 warn rise and fall, R8 strobe
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].rxi, VEC[i].rxs, VEC[i].rxd, VEC[i].txi, VEC[i].txs, VEC[i].txd,
                2'b00, 2'b00, 1'b0);
            chk($sformatf("R1/R3/R8 vector %0d", i), VEC[i].erx, VEC[i].etx, VEC[i].eflg, 2'b00, VEC[i].eirq);
        end

        // R4: passive threshold on the receive counter
        cyc(1'b1, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        cyc(1'b1, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        cyc(1'b1, 4'd1,  1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R4 rx at 127 not passive", 8'd127, 9'd21, 5'b00001, 2'b00, 1'b0);
        cyc(1'b1, 4'd1,  1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R4 rx at 128 passive", 8'd128, 9'd21, 5'b00101, 2'b00, 1'b1);
        cyc(1'b0, 4'd0,  1'b1, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R4 rx back to 127", 8'd127, 9'd21, 5'b00001, 2'b00, 1'b1);

        // R2: receive counter saturates at 255
        for (int k = 0; k < 12; k++) cyc(1'b1, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R2 rx saturated", 8'd255, 9'd21, 5'b00101, 2'b00, 1'b0);
        cyc(1'b1, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R2 rx stays at 255", 8'd255, 9'd21, 5'b00101, 2'b00, 1'b0);

        // R7/R8: overflow flags, set-wins, software clear
        cyc(1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 2'b01, 2'b00, 1'b0);
        chk("R7 ovf set with R8 strobe", 8'd254, 9'd21, 5'b00101, 2'b01, 1'b1);
        idle();
        chk("R8 no strobe when quiet", 8'd254, 9'd21, 5'b00101, 2'b01, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'b01, 2'b01, 1'b0);
        chk("R7 set wins over clear", 8'd254, 9'd21, 5'b00101, 2'b01, 1'b1);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 2'b01, 1'b0);
        chk("R7 software clear", 8'd254, 9'd21, 5'b00101, 2'b00, 1'b0);

        // R6: recover beats a same-cycle increment
        cyc(1'b1, 4'd15, 1'b0, 1'b1, 4'd15, 1'b0, 2'b00, 2'b00, 1'b1);
        chk("R6 recover clears all", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b1);
        idle();
        chk("R6 quiet after recover", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b0);

        // R2: decrement at zero stays zero
        cyc(1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 1'b1, 2'b00, 2'b00, 1'b0);
        chk("R2 floor at zero", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b0);

        // R3/R4/R8: transmit climb, passive crossing together with an overflow
        for (int k = 0; k < 8; k++) cyc(1'b0, 4'd0, 1'b0, 1'b1, 4'd15, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R3 tx warn at 120", 8'd0, 9'd120, 5'b00010, 2'b00, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b1, 4'd8, 1'b0, 2'b10, 2'b00, 1'b0);
        chk("R8 passive and overflow same cycle", 8'd0, 9'd128, 5'b01010, 2'b10, 1'b1);
        idle();
        chk("R8 single strobe", 8'd0, 9'd128, 5'b01010, 2'b10, 1'b0);

        // R5: bus-off above 255 and frozen counters
        for (int k = 0; k < 8; k++) cyc(1'b0, 4'd0, 1'b0, 1'b1, 4'd15, 1'b0, 2'b00, 2'b00, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b1, 4'd7, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R5 tx at 255 not bus-off", 8'd0, 9'd255, 5'b01010, 2'b10, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b1, 4'd1, 1'b0, 2'b00, 2'b00, 1'b0);
        chk("R5 bus-off at 256", 8'd0, 9'd256, 5'b11010, 2'b10, 1'b1);
        cyc(1'b1, 4'd5, 1'b0, 1'b0, 4'd0, 1'b1, 2'b00, 2'b00, 1'b0);
        chk("R5 strobes ignored in bus-off", 8'd0, 9'd256, 5'b11010, 2'b10, 1'b0);

        // R6: recover beats a same-cycle overflow report, leaves bus-off
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'b01, 2'b00, 1'b1);
        chk("R6 recover from bus-off", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b1);

        // R9: reset in mid-run
        cyc(1'b1, 4'd9, 1'b0, 1'b1, 4'd3, 1'b0, 2'b10, 2'b00, 1'b0);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        chk("R9 reset mid-run", 8'd0, 9'd0, 5'b00000, 2'b00, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule